// File: doc/BRIEF.md
# CAN Bit Destuffer

The destuffer sits between the bit-timing sampler and the frame parser of a CAN receiver. Each sampled bus bit reaches it with a valid strobe. The transmitter inserts one opposite-valued bit after every run of five equal bits, and the destuffer removes those inserted bits. It passes the real frame bits on to the parser with their own valid strobe, and it raises a separate one-cycle flag for each bit it drops.

The frame parser drives an enable input that stays high while the current bit lies inside the stuffed part of the frame. The parser lowers it for the CRC delimiter, the ACK slot, the ACK delimiter and end of frame. While the enable is low, every raw bit is forwarded unchanged and no stuffing rule is checked.

The run history is kept on the raw stream, so a dropped bit still counts as the first bit of the next run. A start-of-frame strobe that arrives with the first bit clears the history and the position counters. Two indexes are reported:
- the position of the latest raw bit, which counts stuff bits;
- the position of the latest forwarded frame bit, which does not.

Top module: `can_destuff`

## Requirements
- R1: After reset, `frmValid`, `frmBit`, `stuffSeen` and `stuffErr` are 0, and both `rawIdx` and `frmIdx` are 0.
- R2: Each clock edge that samples `rawValid` high produces, on that same edge, exactly one of `frmValid` or `stuffSeen` as a one-cycle pulse. An edge with `rawValid` low produces neither. Bits leave in the order they arrived.
- R3: Consider a raw bit sampled with `stuffEn` high whose five preceding raw bits are equal, and whose value is the opposite of theirs (window 000001 or 111110, oldest first). That bit raises `stuffSeen` and is not forwarded: `frmValid` stays 0.
- R4: A dropped stuff bit stays in the run history. It counts as the first bit of the next run of equal values.
- R5: While `stuffEn` is low, every raw bit is forwarded with `frmBit` equal to the raw value. Neither `stuffSeen` nor `stuffErr` is raised.
- R6: Consider a raw bit sampled with `stuffEn` high whose five preceding raw bits all share its value (six equal bits). That bit pulses `stuffErr` and is still forwarded. Each further equal bit pulses `stuffErr` again.
- R7: A raw bit sampled with `sofIn` high restarts the frame. Its history becomes that single bit, it is always forwarded, and `rawIdx` and `frmIdx` both return to 0.
- R8: `rawIdx` rises by one for every raw bit that is not a start of frame. `frmIdx` rises by one only for forwarded bits. Both saturate at their all-ones value.
- R9: Raw bits may arrive on every clock with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rawValid | input | 1 | A sampled bus bit is present |
| rawBit | input | 1 | Sampled bus level (0 dominant, 1 recessive) |
| sofIn | input | 1 | This raw bit is the start-of-frame bit |
| stuffEn | input | 1 | Current bit lies inside the stuffed region |
| frmValid | output | 1 | A frame bit is forwarded this cycle |
| frmBit | output | 1 | Forwarded frame bit value |
| stuffSeen | output | 1 | A stuff bit was removed this cycle |
| stuffErr | output | 1 | Six equal bits seen inside the stuffed region |
| rawIdx | output | CNT_W | Index of the latest raw bit since start of frame |
| frmIdx | output | CNT_W | Index of the latest forwarded bit since start of frame |

## Verification
The bench aims at these faults:

| Corner case the bench drives | What a faulty design does |
|---|---|
| A bit following a stuff bit, where the four bits after the dropped bit match its value | A design that forgets stuff bits in its history misses the next stuff bit and forwards an extra bit |
| Runs that straddle a start of frame | A design that carries the history across a frame start sees a stuff bit or an error too early |
| Long runs with the enable low | A design that ignores the enable drops real bits |
| Long runs of equal bits with the enable high | A design that confuses the six-equal case with the stuff case misses the error pulse or drops the sixth bit |
| Several hundred bits with no frame start | A design whose counters wrap instead of saturating shows small index values |

// File: rtl/can_destuff_pkg.sv
package can_destuff_pkg;

  // Per-bit decision handed from control to datapath.
  typedef struct packed {
    logic take;    // a raw bit is consumed this cycle
    logic sof;     // it is a start-of-frame bit
    logic fwd;     // forward it as a frame bit
    logic stuff;   // drop it as a stuff bit
    logic err;     // six equal bits in stuffed region
    logic bitVal;  // raw bit value
  } strobe_t;

endpackage

// File: rtl/can_destuff_ctrl.sv
module can_destuff_ctrl
  import can_destuff_pkg::*;
#(
  parameter int STUFF_LEN = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rawValid,
  input  logic    rawBit,
  input  logic    sofIn,
  input  logic    stuffEn,
  output strobe_t strobes
);

  localparam int RUN_W = $clog2(STUFF_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(STUFF_LEN);

  logic             lastBit;
  logic [RUN_W-1:0] runLen;
  logic             runFull;
  logic             sameBit;
  logic             stuffHit;
  logic             errHit;
  logic [RUN_W-1:0] runNext;

  assign runFull  = (runLen == RUN_FULL);
  assign sameBit  = (rawBit == lastBit) && (runLen != '0);
  assign stuffHit = rawValid && !sofIn && stuffEn && runFull && !sameBit;
  assign errHit   = rawValid && !sofIn && stuffEn && runFull && sameBit;

  always_comb begin
    if (sofIn)            runNext = RUN_W'(1);
    else if (!sameBit)    runNext = RUN_W'(1);
    else if (runFull)     runNext = runLen;
    else                  runNext = runLen + RUN_W'(1);
  end

  always_comb begin
    strobes.take   = rawValid;
    strobes.sof    = rawValid && sofIn;
    strobes.stuff  = stuffHit;
    strobes.fwd    = rawValid && !stuffHit;
    strobes.err    = errHit;
    strobes.bitVal = rawBit;
  end

  // Raw history: stuff bits included.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastBit <= 1'b0;
      runLen  <= '0;
    end else if (rawValid) begin
      lastBit <= rawBit;
      runLen  <= runNext;
    end
  end

  AST_STUFF_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.stuff |-> (rawBit != lastBit) && stuffEn) else $error("stuff"); // R3
  AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.err |-> stuffEn && !sofIn) else $error("err"); // R5
  AST_SOF_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rawValid && sofIn) |=> (runLen == RUN_W'(1))) else $error("sof"); // R7

endmodule

// File: rtl/can_destuff_dp.sv
module can_destuff_dp
  import can_destuff_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strobes,
  output logic             frmValid,
  output logic             frmBit,
  output logic             stuffSeen,
  output logic             stuffErr,
  output logic [CNT_W-1:0] rawIdx,
  output logic [CNT_W-1:0] frmIdx
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frmValid  <= 1'b0;
      frmBit    <= 1'b0;
      stuffSeen <= 1'b0;
      stuffErr  <= 1'b0;
      rawIdx    <= '0;
      frmIdx    <= '0;
    end else begin
      frmValid  <= strobes.fwd;
      stuffSeen <= strobes.stuff;
      stuffErr  <= strobes.err;
      if (strobes.fwd) frmBit <= strobes.bitVal;
      if (strobes.sof) begin
        rawIdx <= '0;
        frmIdx <= '0;
      end else if (strobes.take) begin
        if (rawIdx != CNT_MAX) rawIdx <= rawIdx + 1'b1;
        if (strobes.fwd && frmIdx != CNT_MAX) frmIdx <= frmIdx + 1'b1;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(frmValid && stuffSeen)) else $error("both"); // R2
  AST_STUFF_HOLDS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    stuffSeen |-> $stable(frmIdx)) else $error("idx"); // R8
  AST_ERR_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    stuffErr |-> frmValid) else $error("errfwd"); // R6

endmodule

// File: rtl/can_destuff.sv
module can_destuff
  import can_destuff_pkg::*;
#(
  parameter int STUFF_LEN = 5,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rawValid,
  input  logic             rawBit,
  input  logic             sofIn,
  input  logic             stuffEn,
  output logic             frmValid,
  output logic             frmBit,
  output logic             stuffSeen,
  output logic             stuffErr,
  output logic [CNT_W-1:0] rawIdx,
  output logic [CNT_W-1:0] frmIdx
);

  strobe_t strobes;

  can_destuff_ctrl #(.STUFF_LEN(STUFF_LEN)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rawValid(rawValid), .rawBit(rawBit),
    .sofIn(sofIn), .stuffEn(stuffEn), .strobes(strobes)
  );

  can_destuff_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .frmValid(frmValid), .frmBit(frmBit), .stuffSeen(stuffSeen),
    .stuffErr(stuffErr), .rawIdx(rawIdx), .frmIdx(frmIdx)
  );

  AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    !rawValid |=> !frmValid && !stuffSeen) else $error("noin"); // R2
  AST_IN_GIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    rawValid |=> frmValid || stuffSeen) else $error("lost"); // R9
  AST_SOF_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rawValid && sofIn) |=> (rawIdx == '0) && (frmIdx == '0) && frmValid) else $error("sofidx"); // R7

endmodule

// File: tb/can_destuff_tb_top.sv
module can_destuff_tb_top;

  localparam int CNT_W = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rawValid = 1'b0, rawBit = 1'b0, sofIn = 1'b0, stuffEn = 1'b0;
  logic frmValid, frmBit, stuffSeen, stuffErr;
  logic [CNT_W-1:0] rawIdx, frmIdx;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  can_destuff #(.STUFF_LEN(5), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rawValid(rawValid), .rawBit(rawBit),
    .sofIn(sofIn), .stuffEn(stuffEn), .frmValid(frmValid), .frmBit(frmBit),
    .stuffSeen(stuffSeen), .stuffErr(stuffErr), .rawIdx(rawIdx), .frmIdx(frmIdx)
  );

  // Reference: window of last six raw bits, newest in bit 0.
  logic [5:0] hist = '0;
  int histLen = 0;
  int mRaw = 0;
  int mFrm = 0;
  logic expFv, expBit, expSt, expErr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelStep(input bit sof, input bit b, input bit en);
    logic [5:0] win;
    expBit = b;
    if (sof) begin
      hist = {5'b0, b}; histLen = 1;
      expSt = 0; expErr = 0; expFv = 1;
      mRaw = 0; mFrm = 0;
    end else begin
      win = {hist[4:0], b};
      expSt  = en && histLen >= 5 && (win == 6'b000001 || win == 6'b111110);
      expErr = en && histLen >= 5 && (win == 6'b000000 || win == 6'b111111);
      expFv  = !expSt;
      hist = win;
      if (histLen < 6) histLen++;
      if (mRaw < CMAX) mRaw++;
      if (expFv && mFrm < CMAX) mFrm++;
    end
  endtask

  task automatic checkOut(input string tag);
    chk(frmValid == expFv, {tag, " frmValid"}, frmValid, expFv);
    chk(stuffSeen == expSt, {tag, " stuffSeen"}, stuffSeen, expSt);
    chk(stuffErr == expErr, {tag, " stuffErr"}, stuffErr, expErr);
    if (expFv) chk(frmBit == expBit, {tag, " frmBit"}, frmBit, expBit);
    chk(int'(rawIdx) == mRaw, {tag, " rawIdx"}, rawIdx, mRaw);
    chk(int'(frmIdx) == mFrm, {tag, " frmIdx"}, frmIdx, mFrm);
  endtask

  task automatic sendBit(input bit sof, input bit b, input bit en, input string tag);
    @(negedge clk);
    rawValid = 1; rawBit = b; sofIn = sof; stuffEn = en;
    modelStep(sof, b, en);
    @(posedge clk); #1;
    rawValid = 0; sofIn = 0;
    checkOut(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    rawValid = 0; sofIn = 0;
    @(posedge clk); #1;
    chk(!frmValid && !stuffSeen, {tag, " idle"}, {frmValid, stuffSeen}, 0);
  endtask

  task automatic sendStr(input string s, input bit en, input string tag);
    for (int i = 0; i < s.len(); i++)
      sendBit(i == 0, s[i] == "1", en, tag);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit prev;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(!frmValid && !frmBit && !stuffSeen && !stuffErr, "R1 outputs", frmValid, 0);
    chk(rawIdx == 0 && frmIdx == 0, "R1 indexes", rawIdx, 0);
    @(negedge clk) rst_n = 1;

    // R3: SOF plus four zeros, then a one is stuffing
    sendStr("0000010101", 1, "R3");
    idle("R2");
    // R4: stuff bit starts next run: 11111 0(stuff) 0000 then 1 is stuff
    sendStr("0111110000010", 1, "R4");
    // R5: enable low, long runs forwarded untouched
    sendStr("0000000011111111", 0, "R5");
    // R6: seven equal bits in stuffed region
    sendStr("01111111", 1, "R6");
    sendBit(0, 0, 1, "R6");
    // R7: history does not straddle frame start
    sendStr("1111", 1, "R7");
    sendStr("1000010", 1, "R7");
    // R8: saturation without frame start
    sendBit(1, 0, 0, "R8");
    for (int i = 0; i < 300; i++) sendBit(0, i[0], 1, "R8");

    // R2 R9 random frames, back to back, biased toward runs
    void'($urandom(32'h5eed));
    prev = 0;
    for (int f = 0; f < 120; f++) begin
      int len = 20 + ($urandom % 90);
      int enEnd = len - 10;
      for (int i = 0; i < len; i++) begin
        bit b = (i == 0) ? 1'b0 : (($urandom % 4) != 0 ? prev : !prev);
        prev = b;
        sendBit(i == 0, b, i < enEnd, "R9 random");
      end
      if (($urandom % 3) == 0) idle("R2 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule